// File: doc/BRIEF.md
# Debounced Up/Down Level Stepper

This block keeps a 5-bit level that drives an external resistor ladder, one code step being one thirty-second of the supply. Two sources can move the level. The first source is a pair of up and down requests from the remote command decoder. The second source is a pair of active-low local keys. The keys pass through a two-flop synchronizer and a chatter filter before they take effect.

While any request is held, the level moves one step each time a slow repeat divider expires. The level stops at the ends of its range and does not wrap. Reset presets the level to mid-scale.

All timing counts pulses on `tick_i`, a one-cycle timebase strobe produced elsewhere. The repeat period and the filter length are therefore parameters measured in ticks. With a 1 kHz tick, the defaults give about 280 ms per step and 10 ms of filtering. Every pin is a plain level or strobe. No data stream passes through the block.

Top module: `lvl_stepper`

## Requirements
- R1: `level_o` is 5 bits wide and changes by exactly one code per step, never by more.
- R2: While `rst_n` is low, and after it is released, `level_o` holds the preset value 16 until the first step.
- R3: The level saturates: an up step at 31 leaves it at 31, and a down step at 0 leaves it at 0.
- R4: While a request is held, one step occurs on every STEP_TICKS-th tick counted from the start of the request. The first step falls on tick STEP_TICKS. Dropping all requests restarts this count.
- R5: When up and down are requested at the same time, no step occurs and the level holds.
- R6: Key inputs are active low (0 = pressed). A key's filtered state changes only after the synchronized raw level has differed from it for DEB_TICKS consecutive ticks. A press or release shorter than that is ignored. In the bench configuration, both a press and a release take DEB_TICKS+1 ticks to register.
- R7: Per direction, the command request and the filtered key are combined by OR. `key_up_n_i` steps up and `key_dn_n_i` steps down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; presets the level |
| tick_i | input | 1 | One-cycle timebase strobe |
| cmd_up_i | input | 1 | Up request from the command decoder, active high |
| cmd_dn_i | input | 1 | Down request from the command decoder, active high |
| key_up_n_i | input | 1 | Raw up key, active low |
| key_dn_n_i | input | 1 | Raw down key, active low |
| level_o | output | 5 | Current ladder code |

## Verification
Some properties are checked by assertions on every cycle. The level never moves by more than one code. It never jumps between 0 and 31. It holds whenever both directions are requested. A filtered key state changes only on a tick. Two steps never occur on consecutive cycles.

Other behaviour can only be shown by the bench's scenarios. These cover the exact tick on which each step lands, the restart of the divider when a request drops, the saturation values, the mid-scale preset, and the delay through the filter on press and release. They also show that a chattering key leaves the level unchanged.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10
  } dir_e;

  function automatic dir_e resolve_dir(input logic up, input logic dn);
    if (up && !dn) return DIR_UP;
    else if (dn && !up) return DIR_DN;
    else return DIR_HOLD;
  endfunction
endpackage

// File: rtl/lvl_key_filter.sv
module lvl_key_filter #(
  parameter int unsigned DEB_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic key_raw_n_i,
  output logic pressed_o
);
  localparam int unsigned CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_TICKS - 1);

  logic [1:0]    sync_q;
  logic          state_q;   // filtered level, 1 = released
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      state_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], key_raw_n_i};
      if (sync_q[1] == state_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == CNT_LAST) begin
          state_q <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pressed_o = ~state_q;

  // R6: filtered state may only move on a tick
  p_filter_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pressed_o));
endmodule

// File: rtl/lvl_rate_gen.sv
module lvl_rate_gen
  import lvl_pkg::*;
#(
  parameter int unsigned STEP_TICKS = 280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic up_req_i,
  input  logic dn_req_i,
  output logic step_o,
  output dir_e dir_o
);
  localparam int unsigned CW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_TICKS - 1);

  logic          active;
  logic [CW-1:0] cnt_q;

  assign active = up_req_i | dn_req_i;
  assign step_o = active && tick_i && (cnt_q == CNT_LAST);
  assign dir_o  = resolve_dir(up_req_i, dn_req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  generate
    if (STEP_TICKS > 1) begin : g_spacing
      // R4: steps are spread by at least one tick period
      p_step_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);
    end
  endgenerate
endmodule

// File: rtl/lvl_sat_ctr.sv
module lvl_sat_ctr
  import lvl_pkg::*;
#(
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned PRESET = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  dir_e             dir_i,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] LMAX = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] LPRE = LVL_W'(PRESET);

  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LPRE;
    end else if (step_i) begin
      unique case (dir_i)
        DIR_UP:  if (level_q != LMAX) level_q <= level_q + 1'b1;
        DIR_DN:  if (level_q != '0)   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign level_o = level_q;

  // R1: a change is always a single code
  p_single_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> (level_q == $past(level_q) + 1'b1) || (level_q == $past(level_q) - 1'b1));
  // R3: no wrap at either end
  p_no_wrap_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == LMAX) |=> (level_q != '0));
  p_no_wrap_bot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == '0) |=> (level_q != LMAX));
  // R4: level only moves on a step strobe
  p_move_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(level_q));
endmodule

// File: rtl/lvl_stepper.sv
module lvl_stepper
  import lvl_pkg::*;
#(
  parameter int unsigned LVL_W      = 5,
  parameter int unsigned PRESET     = 16,
  parameter int unsigned STEP_TICKS = 280,
  parameter int unsigned DEB_TICKS  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cmd_up_i,
  input  logic             cmd_dn_i,
  input  logic             key_up_n_i,
  input  logic             key_dn_n_i,
  output logic [LVL_W-1:0] level_o
);
  localparam int unsigned NKEYS = 2;

  logic [NKEYS-1:0] key_raw_n;
  logic [NKEYS-1:0] key_pressed;
  logic             up_req, dn_req, step;
  dir_e             dir;

  assign key_raw_n = {key_dn_n_i, key_up_n_i};

  generate
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
      lvl_key_filter #(.DEB_TICKS(DEB_TICKS)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .key_raw_n_i(key_raw_n[k]), .pressed_o(key_pressed[k])
      );
    end
  endgenerate

  assign up_req = cmd_up_i | key_pressed[0];
  assign dn_req = cmd_dn_i | key_pressed[1];

  lvl_rate_gen #(.STEP_TICKS(STEP_TICKS)) u_rate (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .up_req_i(up_req), .dn_req_i(dn_req),
    .step_o(step), .dir_o(dir)
  );

  lvl_sat_ctr #(.LVL_W(LVL_W), .PRESET(PRESET)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step_i(step), .dir_i(dir), .level_o(level_o)
  );

  // R5: opposing requests never move the level
  p_conflict_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && dn_req) |=> $stable(level_o));
endmodule

// File: tb/sim_lvl_stepper.sv
module sim_lvl_stepper;
  localparam int unsigned STEP = 4;
  localparam int unsigned DEB  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cmd_up = 1'b0, cmd_dn = 1'b0;
  logic       key_up_n = 1'b1, key_dn_n = 1'b1;
  logic [4:0] level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lvl_stepper #(.LVL_W(5), .PRESET(16), .STEP_TICKS(STEP), .DEB_TICKS(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .cmd_up_i(cmd_up), .cmd_dn_i(cmd_dn),
    .key_up_n_i(key_up_n), .key_dn_n_i(key_dn_n),
    .level_o(level)
  );

  // {up, dn, ticks[7:0], expected[4:0]} ; pad bit on top
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 8'd4,   5'd17},
    {1'b0, 1'b1, 1'b0, 8'd8,   5'd19},
    {1'b0, 1'b0, 1'b1, 8'd4,   5'd18},
    {1'b0, 1'b1, 1'b1, 8'd8,   5'd18},
    {1'b0, 1'b0, 1'b0, 8'd8,   5'd18},
    {1'b0, 1'b1, 1'b0, 8'd3,   5'd18},
    {1'b0, 1'b1, 1'b0, 8'd4,   5'd19},
    {1'b0, 1'b1, 1'b0, 8'd60,  5'd31},
    {1'b0, 1'b1, 1'b0, 8'd8,   5'd31},
    {1'b0, 1'b0, 1'b1, 8'd12,  5'd28},
    {1'b0, 1'b0, 1'b1, 8'd200, 5'd0},
    {1'b0, 1'b1, 1'b0, 8'd4,   5'd1}
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: level=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 preset in reset", level, 5'd16);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 preset after reset", level, 5'd16);

    // command vectors: R1 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cmd_up = VEC[v][14];
      cmd_dn = VEC[v][13];
      ticks(int'(VEC[v][12:5]));
      check($sformatf("R4 vector %0d (R1 R3 R5)", v), level, VEC[v][4:0]);
      @(negedge clk);
      cmd_up = 1'b0;
      cmd_dn = 1'b0;
    end

    // reset back to mid-scale
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R2 preset after mid-run reset", level, 5'd16);

    // R6 R7: up key press, filter delay, hold, release delay
    @(negedge clk) key_up_n = 1'b0;
    ticks(DEB + 1);
    check("R6 press still filtering", level, 5'd16);
    ticks(STEP);
    check("R7 up key first step", level, 5'd17);
    @(negedge clk) key_up_n = 1'b1;
    ticks(DEB + 1);
    check("R6 release filtered", level, 5'd18);
    ticks(2 * STEP);
    check("R6 released no step", level, 5'd18);

    // R7: down key
    @(negedge clk) key_dn_n = 1'b0;
    ticks(DEB + 1 + 2 * STEP);
    check("R7 down key steps", level, 5'd16);
    @(negedge clk) key_dn_n = 1'b1;
    ticks(DEB + 1 + 2 * STEP);
    check("R7 down key release", level, 5'd15);

    // R6: chatter shorter than filter is ignored
    for (int g = 0; g < 8; g++) begin
      @(negedge clk) key_up_n = 1'b0;
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      key_up_n = 1'b1;
      ticks(1);
    end
    ticks(3 * STEP);
    check("R6 chatter ignored", level, 5'd15);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule